// File: doc/BRIEF.md
# Hardware Page Table Walker

This block translates a virtual address into a physical page base address by walking a tree of page table entries held in memory. A request carries the virtual address, the root table address, a format select and three access flags (supervisor, store, fetch). The walker reads one entry at a time through a single-outstanding memory port. It follows pointer entries down the tree and checks the access rights of the leaf it reaches. It then writes the leaf back with its referenced bit set, and also its dirty bit when the access is a store. The result is a page-aligned physical base, or a fault shown as an all-ones base.

Two table formats can be chosen per request. The narrow format has two levels, 10-bit indices, and a physical page number that starts at entry bit 10. The wide format has three levels, 9-bit indices, and a physical page number that starts at entry bit 26. In both formats every entry is a 64-bit word (8 bytes) and pages are 4 KiB. A leaf found above the last level maps a large page. For such a leaf the walker merges the virtual page bits that the skipped levels would have indexed into the page number. Entry addresses and the final page base are both compared against a fixed memory size.

Top module: `ptw_walker`

## Requirements
- R1: A one-cycle `start` while idle accepts one request. Exactly one `done` pulse of one cycle follows it, and `fault`/`page_base` are valid during that pulse. `done` and `mem_req` are low after reset.
- R2: Narrow format (`wide_mode`=0) uses 2 levels. The level-0 index is VA[31:22] and the level-1 index is VA[21:12]. The page number is entry bits [63:10].
- R3: Wide format (`wide_mode`=1) uses 3 levels. The indices are VA[38:30], then VA[29:21], then VA[20:12]. The page number is entry bits [63:26].
- R4: VA bits from 31 (narrow) or 38 (wide) up to bit 63 must be all equal. Otherwise the walk faults without any memory access.
- R5: The entry address is the current table base plus index times 8. If that address is at or above `MEM_BYTES`, the walk faults without issuing the read.
- R6: An entry with bit 0 = 1 and bits [4:1] = 0001 is a pointer, and the next base is its page number shifted left by 12. A pointer at the last level makes the walk fault.
- R7: An entry with bit 0 = 1 and bit 1 = 0 is a leaf, and any other non-pointer entry faults. A leaf grants access only if two bits are set. The privilege bit is bit 8 for supervisor requests and bit 7 for user requests. The access bit is bit 4 for fetch, bit 3 for store and bit 2 for load (fetch takes priority over store).
- R8: A granted leaf is written back to the same address before `done`. Bit 5 is set in the written value, bit 6 is also set for a store, and all other bits are unchanged.
- R9: For a leaf at level k, the page base is (page number OR the VPN bits below the level-k index) shifted left by 12.
- R10: If the resulting page base is at or above `MEM_BYTES`, the walk faults. The write-back of R8 still occurs.
- R11: When `fault` is high, `page_base` is all ones. When `fault` is low, `page_base` is page aligned and below `MEM_BYTES`.
- R12: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`, with one access in flight at a time. `mem_we` is high only together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken while idle |
| wide_mode | input | 1 | 0: two-level 10-bit format, 1: three-level 9-bit format |
| req_va | input | 64 | Virtual address to translate |
| req_supervisor | input | 1 | Access made at supervisor privilege |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| root_base | input | 64 | Byte address of the top-level table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | Access completed (read data valid this cycle) |
| mem_rdata | input | 64 | Entry value read |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed |
| page_base | output | 64 | Physical page base, all ones on fault |

## Verification
The bench targets large-page leaves at levels 0 and 1, where a walker that skipped the merge of the low VPN bits would return the wrong base. It tests a leaf whose page lies past the end of memory. A design that checked the bound before the write-back would then miss the referenced-bit update. It also covers a pointer at the last level, which a loose design would treat as a leaf. Badly sign-extended addresses and entry addresses past the top of memory come next; a design that got these wrong would touch memory when it must not. Permission cases cover user access to supervisor-only pages and fetches from non-executable pages, in both formats and under random tables.

// File: rtl/ptw_pkg.sv
// Package: shared encodings for the page table walker.
// Assumes 64-bit entries; bit positions below are the entry format the
// walker decodes and the memory image must follow.
package ptw_pkg;

    localparam int PTE_VALID = 0;   // entry is present
    localparam int PTE_PTR   = 1;   // low bit of the type field
    localparam int PTE_RD    = 2;   // load allowed
    localparam int PTE_WR    = 3;   // store allowed
    localparam int PTE_EX    = 4;   // fetch allowed
    localparam int PTE_REF   = 5;   // referenced status
    localparam int PTE_DIRTY = 6;   // dirty status
    localparam int PTE_USER  = 7;   // user privilege may access
    localparam int PTE_SUPV  = 8;   // supervisor privilege may access

    // Type field [4:1] value that marks a pointer to the next table.
    localparam logic [3:0] PTR_TYPE = 4'b0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK_VA,
        ST_READ_PTE,
        ST_EVAL,
        ST_WRITEBACK,
        ST_DONE
    } ptw_state_e;

    typedef struct packed {
        logic supervisor;
        logic store;
        logic fetch;
    } ptw_access_t;

endpackage

// File: rtl/ptw_va_check.sv
// Module: ptw_va_check
// Checks that the upper bits of a virtual address are a sign extension of
// the top implemented bit, for the format chosen by wide.
// Assumes: widths derived from index bits * levels + page offset.
module ptw_va_check #(
    parameter int ADDR_W        = 64,
    parameter int PAGE_SHIFT    = 12,
    parameter int NARROW_LEVELS = 2,
    parameter int NARROW_IDX    = 10,
    parameter int WIDE_LEVELS   = 3,
    parameter int WIDE_IDX      = 9
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              wide,
    output logic              va_ok
);
    localparam int NARROW_VA = NARROW_IDX * NARROW_LEVELS + PAGE_SHIFT;
    localparam int WIDE_VA   = WIDE_IDX * WIDE_LEVELS + PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic [ADDR_W-1:0] hi_narrow;
    logic [ADDR_W-1:0] hi_wide;
    logic              ok_narrow;
    logic              ok_wide;

    // Purpose: compare the bits at and above the top VA bit with all-0/all-1.
    always_comb begin
        hi_narrow = va >> (NARROW_VA - 1);
        hi_wide   = va >> (WIDE_VA - 1);
        ok_narrow = (hi_narrow == '0) || (hi_narrow == (ALL_ONES >> (NARROW_VA - 1)));
        ok_wide   = (hi_wide == '0) || (hi_wide == (ALL_ONES >> (WIDE_VA - 1)));
        va_ok     = wide ? ok_wide : ok_narrow;
    end

endmodule

// File: rtl/ptw_index_sel.sv
// Module: ptw_index_sel
// Picks the table index for the current level from the virtual page
// number, forms the entry byte address and checks it against memory size.
// Also reports how many VPN bits lie below this level (for large pages).
// Assumes: level is always below the level count of the selected format.
module ptw_index_sel #(
    parameter int              ADDR_W        = 64,
    parameter int              PAGE_SHIFT    = 12,
    parameter int              NARROW_LEVELS = 2,
    parameter int              NARROW_IDX    = 10,
    parameter int              WIDE_LEVELS   = 3,
    parameter int              WIDE_IDX      = 9,
    parameter int              ENTRY_BYTES   = 8,
    parameter longint unsigned MEM_BYTES     = 64'h40_0000,
    parameter int              LVL_W         = 2,
    parameter int              REM_W         = 7
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              wide,
    input  logic [LVL_W-1:0]  level,
    input  logic [ADDR_W-1:0] table_base,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              entry_in_range,
    output logic [REM_W-1:0]  rem_bits,
    output logic              last_level
);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    int                levels;
    int                idx_bits;
    int                left;
    logic [ADDR_W-1:0] idx_mask;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W:0]   sum;

    // Purpose: index extraction, entry address and its bound check.
    always_comb begin
        levels     = wide ? WIDE_LEVELS : NARROW_LEVELS;
        idx_bits   = wide ? WIDE_IDX : NARROW_IDX;
        left       = levels - 1 - int'(level);
        rem_bits   = REM_W'(left * idx_bits);
        last_level = (left == 0);
        idx_mask   = (ADDR_W'(1) << idx_bits) - ADDR_W'(1);
        idx        = (va >> (REM_W'(PAGE_SHIFT) + rem_bits)) & idx_mask;
        sum        = {1'b0, table_base} + {1'b0, (idx << ENTRY_SHIFT)};
        entry_addr = sum[ADDR_W-1:0];
        entry_in_range = !sum[ADDR_W] && (sum[ADDR_W-1:0] < ADDR_W'(MEM_BYTES));
    end

endmodule

// File: rtl/ptw_pte_eval.sv
// Module: ptw_pte_eval
// Decodes a fetched entry: pointer or leaf, access rights, next table
// base, the (possibly large-page) leaf base and its bound check, and the
// value to write back with the status bits set.
// Assumes: status bits lie below the page number field in both formats.
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int              ADDR_W         = 64,
    parameter int              PAGE_SHIFT     = 12,
    parameter int              NARROW_PPN_LSB = 10,
    parameter int              WIDE_PPN_LSB   = 26,
    parameter longint unsigned MEM_BYTES      = 64'h40_0000,
    parameter int              REM_W          = 7
) (
    input  logic [ADDR_W-1:0] pte,
    input  logic              wide,
    input  ptw_access_t       acc,
    input  logic [ADDR_W-1:0] va,
    input  logic [REM_W-1:0]  rem_bits,
    output logic              is_table,
    output logic              leaf_ok,
    output logic [ADDR_W-1:0] next_base,
    output logic [ADDR_W-1:0] leaf_base,
    output logic              leaf_in_range,
    output logic [ADDR_W-1:0] pte_marked
);
    logic [ADDR_W-1:0] ppn;
    logic [ADDR_W-1:0] low_mask;
    logic              priv_ok;
    logic              kind_ok;

    // Purpose: classify the entry and check the requested access.
    always_comb begin
        ppn      = wide ? (pte >> WIDE_PPN_LSB) : (pte >> NARROW_PPN_LSB);
        is_table = pte[PTE_VALID] && (pte[PTE_EX:PTE_PTR] == PTR_TYPE);
        priv_ok  = acc.supervisor ? pte[PTE_SUPV] : pte[PTE_USER];
        kind_ok  = acc.fetch ? pte[PTE_EX] : (acc.store ? pte[PTE_WR] : pte[PTE_RD]);
        leaf_ok  = pte[PTE_VALID] && !pte[PTE_PTR] && priv_ok && kind_ok;
    end

    // Purpose: build next-level base and the merged leaf page base.
    always_comb begin
        next_base     = ppn << PAGE_SHIFT;
        low_mask      = (ADDR_W'(1) << rem_bits) - ADDR_W'(1);
        leaf_base     = (ppn | ((va >> PAGE_SHIFT) & low_mask)) << PAGE_SHIFT;
        leaf_in_range = leaf_base < ADDR_W'(MEM_BYTES);
    end

    // Purpose: entry value for write-back with referenced/dirty marked.
    always_comb begin
        pte_marked            = pte;
        pte_marked[PTE_REF]   = 1'b1;
        if (acc.store) begin
            pte_marked[PTE_DIRTY] = 1'b1;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Page table walker: on start it validates the virtual address, then
// reads one entry per level through a single-outstanding memory port,
// follows pointers, checks rights on the leaf, writes the leaf back with
// status bits set, and reports a page base or a fault (all-ones base).
// Assumes: memory port holds one access at a time and answers with a
// one-cycle mem_ack; start is only honoured in the idle state.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int              ADDR_W         = 64,
    parameter int              PAGE_SHIFT     = 12,
    parameter int              NARROW_LEVELS  = 2,
    parameter int              NARROW_IDX     = 10,
    parameter int              NARROW_PPN_LSB = 10,
    parameter int              WIDE_LEVELS    = 3,
    parameter int              WIDE_IDX       = 9,
    parameter int              WIDE_PPN_LSB   = 26,
    parameter int              ENTRY_BYTES    = 8,
    parameter longint unsigned MEM_BYTES      = 64'h40_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_supervisor,
    input  logic              req_store,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] page_base
);
    localparam int MAX_LEVELS = (WIDE_LEVELS > NARROW_LEVELS) ? WIDE_LEVELS : NARROW_LEVELS;
    localparam int LVL_W      = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1;
    localparam int REM_W      = 7;

    ptw_state_e        state_q;
    logic [ADDR_W-1:0] va_q;
    logic              wide_q;
    ptw_access_t       acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [LVL_W-1:0]  level_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] pte_addr_q;
    logic [ADDR_W-1:0] result_q;
    logic              fault_q;

    logic              va_ok;
    logic [ADDR_W-1:0] entry_addr;
    logic              entry_in_range;
    logic [REM_W-1:0]  rem_bits;
    logic              last_level;
    logic              is_table;
    logic              leaf_ok;
    logic [ADDR_W-1:0] next_base;
    logic [ADDR_W-1:0] leaf_base;
    logic              leaf_in_range;
    logic [ADDR_W-1:0] pte_marked;

    ptw_va_check #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
        .NARROW_LEVELS(NARROW_LEVELS), .NARROW_IDX(NARROW_IDX),
        .WIDE_LEVELS(WIDE_LEVELS), .WIDE_IDX(WIDE_IDX)
    ) u_va_check (
        .va    (va_q),
        .wide  (wide_q),
        .va_ok (va_ok)
    );

    ptw_index_sel #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
        .NARROW_LEVELS(NARROW_LEVELS), .NARROW_IDX(NARROW_IDX),
        .WIDE_LEVELS(WIDE_LEVELS), .WIDE_IDX(WIDE_IDX),
        .ENTRY_BYTES(ENTRY_BYTES), .MEM_BYTES(MEM_BYTES),
        .LVL_W(LVL_W), .REM_W(REM_W)
    ) u_index_sel (
        .va             (va_q),
        .wide           (wide_q),
        .level          (level_q),
        .table_base     (base_q),
        .entry_addr     (entry_addr),
        .entry_in_range (entry_in_range),
        .rem_bits       (rem_bits),
        .last_level     (last_level)
    );

    ptw_pte_eval #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
        .NARROW_PPN_LSB(NARROW_PPN_LSB), .WIDE_PPN_LSB(WIDE_PPN_LSB),
        .MEM_BYTES(MEM_BYTES), .REM_W(REM_W)
    ) u_pte_eval (
        .pte           (pte_q),
        .wide          (wide_q),
        .acc           (acc_q),
        .va            (va_q),
        .rem_bits      (rem_bits),
        .is_table      (is_table),
        .leaf_ok       (leaf_ok),
        .next_base     (next_base),
        .leaf_base     (leaf_base),
        .leaf_in_range (leaf_in_range),
        .pte_marked    (pte_marked)
    );

    // Purpose: walk sequencing, request capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            wide_q     <= 1'b0;
            acc_q      <= '0;
            base_q     <= '0;
            level_q    <= '0;
            pte_q      <= '0;
            pte_addr_q <= '0;
            result_q   <= '1;
            fault_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        va_q    <= req_va;
                        wide_q  <= wide_mode;
                        acc_q   <= '{supervisor: req_supervisor, store: req_store, fetch: req_fetch};
                        state_q <= ST_CHECK_VA;
                    end
                end
                ST_CHECK_VA: begin
                    base_q  <= root_base;
                    level_q <= '0;
                    if (va_ok) begin
                        state_q <= ST_READ_PTE;
                    end else begin
                        result_q <= '1;
                        fault_q  <= 1'b1;
                        state_q  <= ST_DONE;
                    end
                end
                ST_READ_PTE: begin
                    if (!entry_in_range) begin
                        result_q <= '1;
                        fault_q  <= 1'b1;
                        state_q  <= ST_DONE;
                    end else if (mem_ack) begin
                        pte_q      <= mem_rdata;
                        pte_addr_q <= entry_addr;
                        state_q    <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (is_table && !last_level) begin
                        base_q  <= next_base;
                        level_q <= level_q + LVL_W'(1);
                        state_q <= ST_READ_PTE;
                    end else if (!is_table && leaf_ok) begin
                        pte_q   <= pte_marked;
                        state_q <= ST_WRITEBACK;
                    end else begin
                        result_q <= '1;
                        fault_q  <= 1'b1;
                        state_q  <= ST_DONE;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ack) begin
                        result_q <= leaf_in_range ? leaf_base : '1;
                        fault_q  <= !leaf_in_range;
                        state_q  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the memory port from the current state.
    always_comb begin
        mem_req   = ((state_q == ST_READ_PTE) && entry_in_range) || (state_q == ST_WRITEBACK);
        mem_we    = (state_q == ST_WRITEBACK);
        mem_addr  = (state_q == ST_WRITEBACK) ? pte_addr_q : entry_addr;
        mem_wdata = pte_q;
    end

    assign done      = (state_q == ST_DONE);
    assign fault     = fault_q;
    assign page_base = result_q;

    // R1: completion is a single-cycle pulse.
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: fault reported with all-ones base.
    assert_fault_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (&page_base));

    // R10: a good result is aligned and inside memory.
    assert_good_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> ((page_base < ADDR_W'(MEM_BYTES)) && (page_base[PAGE_SHIFT-1:0] == '0)));

    // R12: a pending access holds its request, address, direction and data.
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12: writes only come with a request.
    assert_we_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R8: every write-back marks the entry referenced, and dirty on a store.
    assert_wb_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[PTE_REF] && (!acc_q.store || mem_wdata[PTE_DIRTY])));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned MEM_SZ     = 64'h40_0000;
    localparam logic [63:0]     ONES       = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_supervisor = 1'b0;
    logic        req_store = 1'b0;
    logic        req_fetch = 1'b0;
    logic [63:0] root_base = '0;
    logic        mem_req;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic        fault;
    logic [63:0] page_base;

    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    int rd_count = 0;
    int wait_left = 0;
    logic [63:0] last_wr_addr = '0;
    logic [63:0] last_wr_data = '0;
    logic [63:0] mem_words [logic [63:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker #(.MEM_BYTES(MEM_SZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .req_va(req_va), .req_supervisor(req_supervisor), .req_store(req_store),
        .req_fetch(req_fetch), .root_base(root_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .page_base(page_base)
    );

    function automatic logic [63:0] rd_word(input logic [63:0] a);
        if (mem_words.exists(a >> 3)) return mem_words[a >> 3];
        return '0;
    endfunction

    // Memory model: random 0..2 wait cycles, one-cycle ack.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_left == 0) begin
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        mem_words[mem_addr >> 3] = mem_wdata;
                        wr_count++;
                        last_wr_addr = mem_addr;
                        last_wr_data = mem_wdata;
                    end else begin
                        mem_rdata <= rd_word(mem_addr);
                        rd_count++;
                    end
                    wait_left = int'($urandom % 3);
                end else begin
                    wait_left--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference walk computed from the requirements.
    function automatic void ref_walk(input logic [63:0] va, input bit sup, input bit st,
                                     input bit fe, input bit wide, input logic [63:0] root,
                                     output logic [63:0] base_out, output bit wr,
                                     output logic [63:0] waddr, output logic [63:0] wdata);
        int levels = wide ? 3 : 2;
        int ib     = wide ? 9 : 10;
        int plsb   = wide ? 26 : 10;
        int vab    = ib * levels + 12;
        logic [63:0] hi, b, idx, ea, pte, ppn, pa;
        bit allowed;
        wr = 0; waddr = '0; wdata = '0; base_out = ONES;
        hi = va >> (vab - 1);
        if (hi != 0 && hi != (ONES >> (vab - 1))) return;
        b = root;
        for (int i = 0; i < levels; i++) begin
            int rem = (levels - 1 - i) * ib;
            idx = (va >> (12 + rem)) & ((64'd1 << ib) - 1);
            ea  = b + idx * 8;
            if (ea >= MEM_SZ) return;
            pte = rd_word(ea);
            ppn = pte >> plsb;
            if (pte[0] && pte[4:1] == 4'b0001) begin
                b = ppn << 12;
                continue;
            end
            if (!pte[0] || pte[1]) return;
            allowed = (sup ? pte[8] : pte[7]) && (fe ? pte[4] : (st ? pte[3] : pte[2]));
            if (!allowed) return;
            wr = 1; waddr = ea;
            wdata = pte | 64'h20 | (st ? 64'h40 : 64'h0);
            pa = (ppn | ((va >> 12) & ((64'd1 << rem) - 1))) << 12;
            if (pa < MEM_SZ) base_out = pa;
            return;
        end
    endfunction

    task automatic run_walk(input logic [63:0] va, input bit sup, input bit st, input bit fe,
                            input bit wide, input logic [63:0] root, input string req,
                            input bit expect_no_access);
        logic [63:0] eb, ea, ed;
        bit ew;
        bit seen = 0;
        ref_walk(va, sup, st, fe, wide, root, eb, ew, ea, ed);
        @(negedge clk);
        wr_count = 0; rd_count = 0;
        req_va = va; req_supervisor = sup; req_store = st; req_fetch = fe;
        wide_mode = wide; root_base = root; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, {req, " R1 done"}, 64'(seen), 64'd1);
        if (!seen) return;
        chk(page_base == eb, {req, " base"}, page_base, eb);
        chk(fault == (eb == ONES), {req, " R11 fault"}, 64'(fault), 64'(eb == ONES));
        chk(wr_count == int'(ew), {req, " R8 writes"}, 64'(wr_count), 64'(ew));
        if (ew) begin
            chk(last_wr_addr == ea, {req, " R8 wb addr"}, last_wr_addr, ea);
            chk(last_wr_data == ed, {req, " R8 wb data"}, last_wr_data, ed);
        end
        if (expect_no_access)
            chk(rd_count == 0, {req, " no access"}, 64'(rd_count), 64'd0);
        @(negedge clk);
        chk(!done, {req, " R1 pulse"}, 64'(done), 64'd0);
    endtask

    task automatic rand_trial();
        bit wide = bit'($urandom % 2);
        int levels = wide ? 3 : 2;
        int ib = wide ? 9 : 10;
        int plsb = wide ? 26 : 10;
        int vab = ib * levels + 12;
        logic [63:0] root, va, b, ea, pte, pg;
        int pick;
        mem_words.delete();
        root = 64'($urandom % 1024) << 12;
        va = {32'($urandom), 32'($urandom)} & ((64'd1 << vab) - 1);
        if (va[vab-1]) va = va | ~((64'd1 << vab) - 1);
        if ($urandom % 16 == 0) va[63] = ~va[63];
        b = root;
        for (int i = 0; i < levels; i++) begin
            int rem = (levels - 1 - i) * ib;
            ea = b + (((va >> (12 + rem)) & ((64'd1 << ib) - 1)) * 8);
            pick = int'($urandom % 8);
            if (pick == 0) break;
            if (pick <= 3) begin
                pg  = ($urandom % 8 == 0) ? 64'($urandom % 4096) : 64'($urandom % 1024);
                pte = (pg << plsb) | 64'd1 | (64'($urandom % 8) << 2) | (64'($urandom % 4) << 7);
                if ($urandom % 10 == 0) pte = pte | 64'd2;
                mem_words[ea >> 3] = pte;
                break;
            end
            pg = 64'($urandom % 1024);
            mem_words[ea >> 3] = (pg << plsb) | 64'd3;
            b = pg << 12;
        end
        run_walk(va, bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), wide, root,
                 "R7 random", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!done, "R1 reset done", 64'(done), 64'd0);
        chk(!mem_req, "R12 reset req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: narrow 4 KiB page, user load.
        mem_words.delete();
        mem_words[64'h1008 >> 3] = (64'h2 << 10) | 64'h3;
        mem_words[64'h2018 >> 3] = (64'h55 << 10) | 64'h85;
        run_walk(64'h0040_3123, 0, 0, 0, 0, 64'h1000, "R2 narrow page", 0);

        // R10: leaf page beyond memory, write-back still happens.
        mem_words[64'h2018 >> 3] = (64'h500 << 10) | 64'h85;
        run_walk(64'h0040_3123, 0, 0, 0, 0, 64'h1000, "R10 leaf out of range", 0);

        // R6: pointer at the last level.
        mem_words[64'h2018 >> 3] = (64'h7 << 10) | 64'h3;
        run_walk(64'h0040_3123, 0, 0, 0, 0, 64'h1000, "R6 pointer at last level", 0);

        // R7: user load of a supervisor-only page.
        mem_words[64'h2018 >> 3] = (64'h55 << 10) | 64'h105;
        run_walk(64'h0040_3123, 0, 0, 0, 0, 64'h1000, "R7 user on supervisor page", 0);

        // R7: fetch from a readable, non-executable page.
        mem_words[64'h2018 >> 3] = (64'h55 << 10) | 64'h10D;
        run_walk(64'h0040_3123, 1, 0, 1, 0, 64'h1000, "R7 fetch without execute", 0);

        // R9: narrow large page at level 0, store.
        mem_words[64'h1008 >> 3] = (64'h100 << 10) | 64'h10D;
        run_walk(64'h0040_3123, 1, 1, 0, 0, 64'h1000, "R9 narrow large page", 0);

        // R3 R9: wide large page at level 0 (low 18 VPN bits merged), store.
        mem_words.delete();
        mem_words[64'h3008 >> 3] = (64'h40 << 26) | 64'h10D;
        run_walk((64'd1 << 30) | (64'd1 << 21) | (64'd3 << 12) | 64'hABC, 1, 1, 0, 1, 64'h3000,
                 "R9 wide large page", 0);

        // R3: full three-level wide walk, fetch.
        mem_words.delete();
        mem_words[64'h3010 >> 3] = (64'h5 << 26) | 64'h3;
        mem_words[(64'h5000 + 64'h18) >> 3] = (64'h6 << 26) | 64'h3;
        mem_words[(64'h6000 + 64'h20) >> 3] = (64'h77 << 26) | 64'h195;
        run_walk((64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12), 0, 0, 1, 1, 64'h3000,
                 "R3 wide three levels", 0);

        // R4: badly sign-extended addresses, no memory access.
        run_walk(64'h0000_0001_0000_0000, 0, 0, 0, 0, 64'h1000, "R4 narrow sign", 1);
        run_walk(64'h0000_0040_0000_0000, 0, 0, 0, 1, 64'h3000, "R4 wide sign", 1);

        // R5: entry address at the memory limit, no read issued.
        run_walk(64'h0040_0000, 0, 0, 0, 0, MEM_SZ - 64'd8, "R5 entry out of range", 1);

        for (int t = 0; t < 300; t++) rand_trial();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule